// File: doc/BRIEF.md
# Dual-Plane Pixel Source Selector

This stage sits in the display path of a framebuffer that can show both indexed and true-colour pixels. Each incoming beat carries three words for one screen position: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word is a per-pixel tag. That tag decides whether the pixel comes straight from the direct-colour word or from a palette lookup of the index. The stage then emits one packed 32-bit pixel.

The palette itself lives outside the block. It is reached through a synchronous read port whose data appears one clock after the address. Direct-colour pixels are delayed by the same single stage, so pixels leave in the order they came in. Input and output use valid/ready handshakes. A stalled output freezes the stage without losing or repeating a pixel. A static configuration input selects whether red or blue sits in the low byte of the output word.

Top module: `pixel_source_sel`

## Requirements
- R1: A pixel whose control word has bits [31:24] equal to 8'h03 takes its colour from the direct-colour word. Bits [23:0] of the control word have no effect.
- R2: In the direct-colour word, bits [23:16] are blue, bits [15:8] are green and bits [7:0] are red. Bits [31:24] have no effect on the output.
- R3: A pixel with any other tag is looked up in the palette. In the cycle it is accepted, pal_rd_en is 1 and pal_rd_addr equals in_index. The palette returns {red[23:16], green[15:8], blue[7:0]} on pal_rd_data one cycle later. pal_rd_en is 0 in every other cycle, including cycles that accept a direct pixel.
- R4: With cfg_bgr=0 the output is {8'h00, red, green, blue}. With cfg_bgr=1 it is {8'h00, blue, green, red}. Bits [31:24] of out_pixel are always 0 while out_valid is 1.
- R5: A pixel accepted in one cycle is presented on out_valid/out_pixel in the next cycle. Pixels leave in the order they were accepted, with at most one pixel held in the stage.
- R6: While out_valid=1 and out_ready=0, out_valid stays 1 and out_pixel stays unchanged, even if pal_rd_data changes. No pixel is dropped or duplicated.
- R7: in_ready equals (not out_valid) or out_ready, so one pixel per cycle flows when the output is always ready.
- R8: After reset, out_valid is 0, in_ready is 1 and pal_rd_en is 0 while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bgr | input | 1 | Output byte order: 0 gives red high, 1 gives blue high |
| in_valid | input | 1 | Input pixel beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_index | input | 8 | Palette index plane value |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control plane word; bits [31:24] are the tag |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette entry, one cycle after the read |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pixel | output | 32 | Packed output pixel |

## Verification
A wrong source flag in the stage register makes a pixel show the direct word where a palette entry belongs, or the reverse. That error reaches out_pixel in the cycle right after acceptance. A palette hold register that is stale or never captured only shows up under a stall: the second cycle of a stall displays the palette port's idle value, which the bench makes distinct on purpose. A fault in occupancy or handshake makes out_valid disagree with the bench's queue depth within one cycle. The result is a missing or repeated pixel.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

  localparam int unsigned COMP_W = 8;
  localparam logic [7:0]  DIRECT_TAG = 8'h03;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] green;
    logic [COMP_W-1:0] blue;
  } rgb_t;

  // Tag sits in the most significant byte of the control word.
  function automatic logic tag_is_direct(input logic [31:0] ctrl);
    return ctrl[31:24] == DIRECT_TAG;
  endfunction

  // Direct word is blue/green/red from bit 23 downward; top byte unused.
  function automatic rgb_t unpack_direct(input logic [31:0] word);
    rgb_t c;
    c.red   = word[7:0];
    c.green = word[15:8];
    c.blue  = word[23:16];
    return c;
  endfunction

  function automatic rgb_t unpack_palette(input logic [23:0] entry);
    rgb_t c;
    c.red   = entry[23:16];
    c.green = entry[15:8];
    c.blue  = entry[7:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_pixel(input rgb_t c, input logic bgr);
    if (bgr) return {8'h00, c.blue, c.green, c.red};
    return {8'h00, c.red, c.green, c.blue};
  endfunction

endpackage

// File: rtl/pxsel_stage.sv
module pxsel_stage
  import pxsel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        drain,
  input  logic        take_direct,
  input  logic [31:0] take_word,
  output logic        st_valid,
  output logic        st_direct,
  output rgb_t        st_rgb,
  output logic        st_pal_fresh
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid     <= 1'b0;
      st_direct    <= 1'b0;
      st_rgb       <= '0;
      st_pal_fresh <= 1'b0;
    end else begin
      st_pal_fresh <= take && !take_direct;
      if (take) begin
        st_valid  <= 1'b1;
        st_direct <= take_direct;
        st_rgb    <= unpack_direct(take_word);
      end else if (drain) begin
        st_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pxsel_pal_hold.sv
module pxsel_pal_hold
  import pxsel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fresh,
  input  logic [23:0] pal_data,
  output rgb_t        pal_now
);

  rgb_t held;
  rgb_t live;

  assign live    = unpack_palette(pal_data);
  assign pal_now = fresh ? live : held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (fresh) held <= live;
  end

  // A captured entry stays put until the next palette return.
  assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fresh && !$past(fresh)) |-> $stable(held));

endmodule

// File: rtl/pxsel_pack.sv
module pxsel_pack
  import pxsel_pkg::*;
(
  input  logic        use_direct,
  input  rgb_t        direct_rgb,
  input  rgb_t        pal_rgb,
  input  logic        bgr,
  output logic [31:0] pixel
);

  rgb_t chosen;

  assign chosen = use_direct ? direct_rgb : pal_rgb;
  assign pixel  = pack_pixel(chosen, bgr);

endmodule

// File: rtl/pixel_source_sel.sv
module pixel_source_sel
  import pxsel_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bgr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [31:0]      in_direct,
  input  logic [31:0]      in_ctrl,
  output logic             pal_rd_en,
  output logic [IDX_W-1:0] pal_rd_addr,
  input  logic [23:0]      pal_rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_pixel
);

  logic accept;
  logic pop;
  logic in_is_direct;
  logic st_valid;
  logic st_direct;
  logic st_fresh;
  rgb_t st_rgb;
  rgb_t pal_now;

  assign in_is_direct = tag_is_direct(in_ctrl);
  assign in_ready     = !st_valid || out_ready;
  assign accept       = in_valid && in_ready;
  assign pop          = st_valid && out_ready;
  assign pal_rd_en    = accept && !in_is_direct;
  assign pal_rd_addr  = in_index;
  assign out_valid    = st_valid;

  pxsel_stage u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (accept),
    .drain        (pop),
    .take_direct  (in_is_direct),
    .take_word    (in_direct),
    .st_valid     (st_valid),
    .st_direct    (st_direct),
    .st_rgb       (st_rgb),
    .st_pal_fresh (st_fresh)
  );

  pxsel_pal_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .fresh    (st_fresh),
    .pal_data (pal_rd_data),
    .pal_now  (pal_now)
  );

  pxsel_pack u_pack (
    .use_direct (st_direct),
    .direct_rgb (st_rgb),
    .pal_rgb    (pal_now),
    .bgr        (cfg_bgr),
    .pixel      (out_pixel)
  );

  assert_accept_emits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_palette_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_en |=> (out_valid && !st_direct && st_fresh));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && (out_pixel == $past(out_pixel) || cfg_bgr != $past(cfg_bgr))));

  assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid) |=> out_valid);

  assert_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pixel[31:24] == 8'h00));

endmodule

// File: tb/pixel_source_sel_bench.sv
module pixel_source_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bgr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_index = '0;
  logic [31:0] in_direct = '0;
  logic [31:0] in_ctrl = '0;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_addr;
  logic [23:0] pal_rd_data = 24'h5A5A5A;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pixel_source_sel u_pixel_source_sel (
    .clk(clk), .rst_n(rst_n), .cfg_bgr(cfg_bgr),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .in_direct(in_direct), .in_ctrl(in_ctrl),
    .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  function automatic logic [23:0] pal_entry(input logic [7:0] i);
    return {i ^ 8'h3C, i + 8'd7, ~i};
  endfunction

  // Palette model: data only meaningful the cycle after a read.
  always @(posedge clk) pal_rd_data <= pal_rd_en ? pal_entry(pal_rd_addr) : 24'h5A5A5A;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [23:0] exp_q[$];
  bit          kind_q[$];

  function automatic logic [31:0] expect_pix(input logic [23:0] rgb, input logic bgr);
    // rgb holds {red, green, blue}
    return bgr ? {8'h00, rgb[7:0], rgb[15:8], rgb[23:16]} : {8'h00, rgb};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    bit          prev_stall;
    logic [31:0] prev_pix;
    logic        prev_bgr;
    logic [7:0]  tags[6];
    tags = '{8'h03, 8'h00, 8'h02, 8'h04, 8'h83, 8'hFF};
    prev_stall = 0;
    prev_pix = '0;
    prev_bgr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R8 in_ready after reset", {31'd0, in_ready}, 32'd1);
    check(pal_rd_en == 1'b0, "R8 pal_rd_en idle", {31'd0, pal_rd_en}, 32'd0);
    rst_n = 1'b1;
    for (int phase = 0; phase < 5; phase++) begin
      for (int cyc = 0; cyc < 600; cyc++) begin
        bit direct_pick;
        @(negedge clk);
        // drive
        case (phase)
          0: begin cfg_bgr = 0; in_valid = 1; out_ready = 1; end
          1: begin cfg_bgr = 1; in_valid = ($urandom % 4) != 0; out_ready = 1; end
          2: begin cfg_bgr = 0; in_valid = ($urandom % 3) != 0; out_ready = ($urandom % 2) != 0; end
          3: begin cfg_bgr = 1; in_valid = ($urandom % 4) != 0; out_ready = ($urandom % 10) < 3; end
          default: begin cfg_bgr = 0; in_valid = (cyc < 580); out_ready = ($urandom % 3) != 0; end
        endcase
        in_index  = 8'($urandom);
        in_direct = $urandom;
        case (phase)
          0: in_ctrl = {8'h01 + 8'($urandom % 2), 24'($urandom)};
          1: in_ctrl = {8'h03, 24'($urandom)};
          default: in_ctrl = {tags[$urandom % 6], 24'($urandom)};
        endcase
        #1;
        // compare against model
        check(out_valid == (exp_q.size() > 0), "R5 out_valid vs pending", {31'd0, out_valid}, {31'd0, exp_q.size() > 0});
        check(in_ready == (!(exp_q.size() > 0) || out_ready), "R7 in_ready", {31'd0, in_ready}, {31'd0, !(exp_q.size() > 0) || out_ready});
        if (exp_q.size() > 0 && out_valid) begin
          if (kind_q[0]) check(out_pixel == expect_pix(exp_q[0], cfg_bgr), "R1 R2 R4 direct pixel", out_pixel, expect_pix(exp_q[0], cfg_bgr));
          else           check(out_pixel == expect_pix(exp_q[0], cfg_bgr), "R3 R4 palette pixel", out_pixel, expect_pix(exp_q[0], cfg_bgr));
        end
        if (prev_stall && prev_bgr == cfg_bgr)
          check(out_valid && out_pixel == prev_pix, "R6 stall hold", out_pixel, prev_pix);
        direct_pick = (in_ctrl[31:24] == 8'h03);
        check(pal_rd_en == (in_valid && in_ready && !direct_pick), "R3 read strobe", {31'd0, pal_rd_en}, {31'd0, in_valid && in_ready && !direct_pick});
        if (pal_rd_en)
          check(pal_rd_addr == in_index, "R3 read address", {24'd0, pal_rd_addr}, {24'd0, in_index});
        // model update
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pixel;
        prev_bgr   = cfg_bgr;
        if (exp_q.size() > 0 && out_ready) begin
          void'(exp_q.pop_front());
          void'(kind_q.pop_front());
        end
        if (in_valid && in_ready) begin
          exp_q.push_back(direct_pick ? {in_direct[7:0], in_direct[15:8], in_direct[23:16]} : pal_entry(in_index));
          kind_q.push_back(direct_pick);
        end
      end
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = 1;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 || !out_valid, "R5 drained", {31'd0, out_valid}, 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule